// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the register storage of a small 8-bit processor core. It keeps two copies of the accumulator/flag pair and two copies of the three general-purpose 16-bit pairs. Two select bits pick which copy is live. The AF copy and the general-purpose copy each have their own bit. The same block also stores the stack pointer, two 16-bit index registers, an 8-bit interrupt vector base and an 8-bit refresh counter. The inactive copies have no address of their own. The only way to reach them is to flip the matching select bit.

The surrounding core reads two 8-bit registers and one 16-bit pair at a time, with no clock delay. It writes at most one 8-bit register and one 16-bit pair per clock. It also raises single-cycle strobes for these operations:
- toggling the AF bank;
- toggling the general-purpose bank;
- exchanging the active DE and HL pairs;
- an opcode or prefix fetch, which advances the refresh counter.

The vector base and the refresh counter can be loaded from the active accumulator. Their current values are always present on output ports, so the core can move them back to the accumulator.

Top module: `cpu_regbank`

## Requirements
- R1: While `rst_n` is low the vector base, the refresh counter and both bank select bits are cleared, so reads after reset come from the first bank. The data registers themselves are not reset.
- R2: The 8-bit register codes are 000=B, 001=C, 010=D, 011=E, 100=H, 101=L and 111=A. Both 8-bit read ports return the addressed register of the active bank, combinationally. Code 110 reads as 0x00. An 8-bit write with code 110 changes no register.
- R3: With pair map 00, the pair codes are 00=BC, 01=DE, 10=HL and 11=SP. The pair read port places the high register (B, D, H) on bits 15:8 and the low register on bits 7:0. The 16-bit write port uses the same layout.
- R4: Pair map 01 is identical to map 00, except that code 11 selects AF (A on bits 15:8, flags on 7:0). Pair map 10 selects IX when bit 0 of the pair code is 0 and IY when it is 1. Pair map 11 reads 0x0000 and writes nothing.
- R5: An AF-swap strobe toggles only the AF select bit. A and F switch to the other copy, and B, C, D, E, H, L are unaffected.
- R6: A general-swap strobe toggles only the BC/DE/HL select bit. A and F are unaffected.
- R7: The DE/HL exchange strobe swaps the contents of the active DE and HL pairs in one clock.
- R8: Each fetch strobe adds one to bits 6:0 of the refresh counter, wrapping from 0x7F to 0x00. Bit 7 keeps its value, so 0xFF steps to 0x80.
- R9: Load-vector copies the active A into the vector base. Load-refresh copies the active A into the refresh counter, and takes priority over a fetch strobe in the same clock.
- R10: A write in the same clock as a swap strobe lands in the bank that was active before the swap.
- R11: When writes overlap in one clock, the 8-bit write takes priority over the 16-bit write on the shared register. Either write also takes priority over the DE/HL exchange for the register it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 3 | Register code for 8-bit read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 3 | Register code for 8-bit read port B |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_map | input | 2 | Pair mapping for the pair read port |
| rd_pair_sel | input | 2 | Pair code for the pair read port |
| rd_pair_data | output | 16 | Pair read data, high register on 15:8 |
| wr8_en | input | 1 | 8-bit write enable |
| wr8_sel | input | 3 | 8-bit write register code |
| wr8_data | input | 8 | 8-bit write data |
| wr16_en | input | 1 | 16-bit write enable |
| wr16_map | input | 2 | Pair mapping for the 16-bit write |
| wr16_sel | input | 2 | Pair code for the 16-bit write |
| wr16_data | input | 16 | 16-bit write data |
| swap_af | input | 1 | Toggle the AF bank select |
| swap_gen | input | 1 | Toggle the BC/DE/HL bank select |
| xchg_dehl | input | 1 | Exchange active DE and HL |
| fetch_stb | input | 1 | Opcode or prefix fetch, advances refresh counter |
| ld_ivec | input | 1 | Load vector base from active A |
| ld_rfsh | input | 1 | Load refresh counter from active A |
| ivec_val | output | 8 | Current vector base |
| rfsh_val | output | 8 | Current refresh counter |

## Verification
Each register code is written with a distinct byte and read back on both 8-bit ports, which exposes any swapped or aliased code. Writing the reserved code last and then re-reading every register shows whether that write leaked into real storage. Bank tests first give the second copy values that differ from the first, so a swap that copies data, or one that flips the wrong select bit, returns the wrong byte. The refresh counter is loaded with values just below both wrap points so that the behaviour of bit 7 is visible. The same-clock cases (write with swap, overlapping writes, exchange with write) each give a different result for every possible priority order.

// File: rtl/cpu_regbank_pkg.sv
package cpu_regbank_pkg;
    localparam int BYTE_W  = 8;
    localparam int PAIR_W  = 2 * BYTE_W;
    localparam int CODE_W  = 3;
    localparam int PCODE_W = 2;
    localparam int MAP_W   = 2;
    localparam int NUM_GEN = 6;   // B C D E H L
    localparam int NUM_BANK = 2;

    localparam logic [CODE_W-1:0] CODE_MEM = 3'b110;
    localparam logic [CODE_W-1:0] CODE_ACC = 3'b111;

    typedef enum logic [MAP_W-1:0] {
        MAP_GEN   = 2'b00,
        MAP_STACK = 2'b01,
        MAP_INDEX = 2'b10,
        MAP_NONE  = 2'b11
    } pair_map_e;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        logic [NUM_BANK-1:0][NUM_GEN-1:0][BYTE_W-1:0] gen;
        logic [NUM_BANK-1:0][BYTE_W-1:0]              acc;
        logic [NUM_BANK-1:0][BYTE_W-1:0]              flg;
        pair_t                                        sp;
        pair_t                                        ix;
        pair_t                                        iy;
        byte_t                                        ivec;
        byte_t                                        rfsh;
        logic                                         sel_af;
        logic                                         sel_gen;
    } rf_state_t;
endpackage

// File: rtl/cpu_regbank_rd8.sv
module cpu_regbank_rd8
    import cpu_regbank_pkg::*;
(
    input  logic [NUM_GEN-1:0][BYTE_W-1:0] bank,
    input  byte_t                          acc,
    input  logic [CODE_W-1:0]              sel,
    output byte_t                          data
);
    always_comb begin
        if (sel == CODE_ACC) begin
            data = acc;
        end else if (sel == CODE_MEM) begin
            data = '0;
        end else begin
            data = bank[sel];
        end
    end
endmodule

// File: rtl/cpu_regbank_rfsh.sv
module cpu_regbank_rfsh
    import cpu_regbank_pkg::*;
(
    input  byte_t rfsh_q,
    input  logic  fetch,
    input  logic  load,
    input  byte_t load_val,
    output byte_t rfsh_d
);
    always_comb begin
        if (load) begin
            rfsh_d = load_val;
        end else if (fetch) begin
            rfsh_d = {rfsh_q[BYTE_W-1], rfsh_q[BYTE_W-2:0] + 1'b1};
        end else begin
            rfsh_d = rfsh_q;
        end
    end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import cpu_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  rd_a_sel,
    output logic [BYTE_W-1:0]  rd_a_data,
    input  logic [CODE_W-1:0]  rd_b_sel,
    output logic [BYTE_W-1:0]  rd_b_data,
    input  logic [MAP_W-1:0]   rd_pair_map,
    input  logic [PCODE_W-1:0] rd_pair_sel,
    output logic [PAIR_W-1:0]  rd_pair_data,
    input  logic               wr8_en,
    input  logic [CODE_W-1:0]  wr8_sel,
    input  logic [BYTE_W-1:0]  wr8_data,
    input  logic               wr16_en,
    input  logic [MAP_W-1:0]   wr16_map,
    input  logic [PCODE_W-1:0] wr16_sel,
    input  logic [PAIR_W-1:0]  wr16_data,
    input  logic               swap_af,
    input  logic               swap_gen,
    input  logic               xchg_dehl,
    input  logic               fetch_stb,
    input  logic               ld_ivec,
    input  logic               ld_rfsh,
    output logic [BYTE_W-1:0]  ivec_val,
    output logic [BYTE_W-1:0]  rfsh_val
);
    localparam int NUM_RD = 2;

    rf_state_t st_d, st_q;
    byte_t     rfsh_d;
    logic      bank_af_q, bank_gen_q;
    byte_t     acc_act;
    logic [NUM_GEN-1:0][BYTE_W-1:0] gen_act;

    assign bank_af_q  = st_q.sel_af;
    assign bank_gen_q = st_q.sel_gen;
    assign acc_act    = st_q.acc[bank_af_q];
    assign gen_act    = st_q.gen[bank_gen_q];
    assign ivec_val   = st_q.ivec;
    assign rfsh_val   = st_q.rfsh;

    // 8-bit read ports
    logic [NUM_RD-1:0][CODE_W-1:0] rd_sel_arr;
    byte_t                         rd_data_arr [NUM_RD];

    assign rd_sel_arr[0] = rd_a_sel;
    assign rd_sel_arr[1] = rd_b_sel;
    assign rd_a_data     = rd_data_arr[0];
    assign rd_b_data     = rd_data_arr[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        cpu_regbank_rd8 rd_i (
            .bank (gen_act),
            .acc  (acc_act),
            .sel  (rd_sel_arr[p]),
            .data (rd_data_arr[p])
        );
    end

    // Pair read port
    always_comb begin
        rd_pair_data = '0;
        case (pair_map_e'(rd_pair_map))
            MAP_GEN, MAP_STACK: begin
                case (rd_pair_sel)
                    2'd0: rd_pair_data = {gen_act[0], gen_act[1]};
                    2'd1: rd_pair_data = {gen_act[2], gen_act[3]};
                    2'd2: rd_pair_data = {gen_act[4], gen_act[5]};
                    default: begin
                        if (pair_map_e'(rd_pair_map) == MAP_GEN) begin
                            rd_pair_data = st_q.sp;
                        end else begin
                            rd_pair_data = {acc_act, st_q.flg[bank_af_q]};
                        end
                    end
                endcase
            end
            MAP_INDEX: rd_pair_data = rd_pair_sel[0] ? st_q.iy : st_q.ix;
            default:   rd_pair_data = '0;
        endcase
    end

    // Refresh counter
    cpu_regbank_rfsh rfsh_i (
        .rfsh_q   (st_q.rfsh),
        .fetch    (fetch_stb),
        .load     (ld_rfsh),
        .load_val (acc_act),
        .rfsh_d   (rfsh_d)
    );

    // Next state: exchange first, then 16-bit write, then 8-bit write
    always_comb begin
        st_d = st_q;

        if (xchg_dehl) begin
            st_d.gen[bank_gen_q][2] = st_q.gen[bank_gen_q][4];
            st_d.gen[bank_gen_q][3] = st_q.gen[bank_gen_q][5];
            st_d.gen[bank_gen_q][4] = st_q.gen[bank_gen_q][2];
            st_d.gen[bank_gen_q][5] = st_q.gen[bank_gen_q][3];
        end

        if (wr16_en) begin
            case (pair_map_e'(wr16_map))
                MAP_GEN, MAP_STACK: begin
                    case (wr16_sel)
                        2'd0: {st_d.gen[bank_gen_q][0], st_d.gen[bank_gen_q][1]} = wr16_data;
                        2'd1: {st_d.gen[bank_gen_q][2], st_d.gen[bank_gen_q][3]} = wr16_data;
                        2'd2: {st_d.gen[bank_gen_q][4], st_d.gen[bank_gen_q][5]} = wr16_data;
                        default: begin
                            if (pair_map_e'(wr16_map) == MAP_GEN) begin
                                st_d.sp = wr16_data;
                            end else begin
                                {st_d.acc[bank_af_q], st_d.flg[bank_af_q]} = wr16_data;
                            end
                        end
                    endcase
                end
                MAP_INDEX: begin
                    if (wr16_sel[0]) begin
                        st_d.iy = wr16_data;
                    end else begin
                        st_d.ix = wr16_data;
                    end
                end
                default: ;
            endcase
        end

        if (wr8_en) begin
            if (wr8_sel == CODE_ACC) begin
                st_d.acc[bank_af_q] = wr8_data;
            end else if (wr8_sel != CODE_MEM) begin
                st_d.gen[bank_gen_q][wr8_sel] = wr8_data;
            end
        end

        if (ld_ivec) begin
            st_d.ivec = acc_act;
        end
        st_d.rfsh    = rfsh_d;
        st_d.sel_af  = st_q.sel_af ^ swap_af;
        st_d.sel_gen = st_q.sel_gen ^ swap_gen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ivec    <= '0;
            st_q.rfsh    <= '0;
            st_q.sel_af  <= 1'b0;
            st_q.sel_gen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cpu_regbank_chk.sv
module cpu_regbank_chk
    import cpu_regbank_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  swap_af,
    input logic  swap_gen,
    input logic  fetch_stb,
    input logic  ld_ivec,
    input logic  ld_rfsh,
    input logic  bank_af,
    input logic  bank_gen,
    input byte_t acc,
    input byte_t ivec_val,
    input byte_t rfsh_val
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ivec_val == '0 && rfsh_val == '0 && !bank_af && !bank_gen));

    assert_af_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_af |=> bank_af != $past(bank_af));

    assert_af_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_af |=> $stable(bank_af));

    assert_gen_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_gen |=> bank_gen != $past(bank_gen));

    assert_gen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_gen |=> $stable(bank_gen));

    assert_rfsh_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !ld_rfsh) |=>
            (rfsh_val[BYTE_W-2:0] == $past(rfsh_val[BYTE_W-2:0]) + 7'd1
             && rfsh_val[BYTE_W-1] == $past(rfsh_val[BYTE_W-1])));

    assert_rfsh_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stb && !ld_rfsh) |=> $stable(rfsh_val));

    assert_rfsh_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rfsh |=> rfsh_val == $past(acc));

    assert_ivec_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ivec |=> ivec_val == $past(acc));
endmodule

bind cpu_regbank cpu_regbank_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_af   (swap_af),
    .swap_gen  (swap_gen),
    .fetch_stb (fetch_stb),
    .ld_ivec   (ld_ivec),
    .ld_rfsh   (ld_rfsh),
    .bank_af   (bank_af_q),
    .bank_gen  (bank_gen_q),
    .acc       (acc_act),
    .ivec_val  (ivec_val),
    .rfsh_val  (rfsh_val)
);

// File: tb/cpu_regbank_tb_top.sv
module cpu_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
    logic [7:0]  rd_a_data, rd_b_data;
    logic [1:0]  rd_pair_map = '0, rd_pair_sel = '0;
    logic [15:0] rd_pair_data;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_sel = '0;
    logic [7:0]  wr8_data = '0;
    logic        wr16_en = 1'b0;
    logic [1:0]  wr16_map = '0, wr16_sel = '0;
    logic [15:0] wr16_data = '0;
    logic        swap_af = 1'b0, swap_gen = 1'b0, xchg_dehl = 1'b0;
    logic        fetch_stb = 1'b0, ld_ivec = 1'b0, ld_rfsh = 1'b0;
    logic [7:0]  ivec_val, rfsh_val;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cpu_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .rd_pair_map(rd_pair_map), .rd_pair_sel(rd_pair_sel), .rd_pair_data(rd_pair_data),
        .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
        .wr16_en(wr16_en), .wr16_map(wr16_map), .wr16_sel(wr16_sel), .wr16_data(wr16_data),
        .swap_af(swap_af), .swap_gen(swap_gen), .xchg_dehl(xchg_dehl),
        .fetch_stb(fetch_stb), .ld_ivec(ld_ivec), .ld_rfsh(ld_rfsh),
        .ivec_val(ivec_val), .rfsh_val(rfsh_val)
    );

    // code, data
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 8'h12}, {3'd1, 8'h34}, {3'd2, 8'h56}, {3'd3, 8'h78},
        {3'd4, 8'h9A}, {3'd5, 8'hBC}, {3'd7, 8'hDE}, {3'd6, 8'hEE}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        wr8_en = 0; wr16_en = 0; swap_af = 0; swap_gen = 0;
        xchg_dehl = 0; fetch_stb = 0; ld_ivec = 0; ld_rfsh = 0;
    endtask

    task automatic w8(input logic [2:0] s, input logic [7:0] d);
        wr8_en = 1; wr8_sel = s; wr8_data = d;
    endtask

    task automatic w16(input logic [1:0] m, input logic [1:0] s, input logic [15:0] d);
        wr16_en = 1; wr16_map = m; wr16_sel = s; wr16_data = d;
    endtask

    task automatic chk8(input string req, input logic [2:0] s, input logic [7:0] exp);
        rd_a_sel = s; rd_b_sel = s;
        #1;
        check(req, {8'h00, rd_a_data}, {8'h00, exp});
        check(req, {8'h00, rd_b_data}, {8'h00, exp});
    endtask

    task automatic chk16(input string req, input logic [1:0] m, input logic [1:0] s, input logic [15:0] exp);
        rd_pair_map = m; rd_pair_sel = s;
        #1;
        check(req, rd_pair_data, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears vector base and refresh counter
        repeat (3) @(posedge clk);
        #1;
        check("R1 ivec", {8'h00, ivec_val}, 16'h0000);
        check("R1 rfsh", {8'h00, rfsh_val}, 16'h0000);
        rst_n = 1;
        step();

        // R2: vector table, write then read every code
        for (int k = 0; k < 8; k++) begin
            w8(VEC[k][10:8], VEC[k][7:0]);
            step();
            chk8("R2 write/read", VEC[k][10:8], (VEC[k][10:8] == 3'd6) ? 8'h00 : VEC[k][7:0]);
        end
        for (int k = 0; k < 7; k++) begin
            chk8("R2 code 110 left storage intact", VEC[k][10:8], VEC[k][7:0]);
        end

        // R3: pair reads and SP
        chk16("R3 BC", 2'd0, 2'd0, 16'h1234);
        chk16("R3 DE", 2'd0, 2'd1, 16'h5678);
        chk16("R3 HL", 2'd0, 2'd2, 16'h9ABC);
        w16(2'd0, 2'd3, 16'hFFFE); step();
        chk16("R3 SP", 2'd0, 2'd3, 16'hFFFE);

        // R4: AF mapping, index regs, unused map
        w16(2'd1, 2'd3, 16'hDE5A); step();
        chk16("R4 AF", 2'd1, 2'd3, 16'hDE5A);
        chk16("R4 SP untouched", 2'd0, 2'd3, 16'hFFFE);
        w16(2'd2, 2'd0, 16'h1000); step();
        w16(2'd2, 2'd1, 16'h2000); step();
        chk16("R4 IX", 2'd2, 2'd0, 16'h1000);
        chk16("R4 IY", 2'd2, 2'd1, 16'h2000);
        w16(2'd3, 2'd0, 16'hBEEF); step();
        chk16("R4 map 11 reads zero", 2'd3, 2'd0, 16'h0000);
        chk16("R4 map 11 write ignored", 2'd0, 2'd0, 16'h1234);

        // R5: AF swap
        swap_af = 1; step();
        w16(2'd1, 2'd3, 16'h0142); step();
        chk16("R5 alt AF", 2'd1, 2'd3, 16'h0142);
        chk8("R5 B unaffected", 3'd0, 8'h12);
        swap_af = 1; step();
        chk16("R5 main AF back", 2'd1, 2'd3, 16'hDE5A);

        // R6: general swap
        swap_gen = 1; step();
        w8(3'd0, 8'hAA); step();
        chk8("R6 alt B", 3'd0, 8'hAA);
        chk8("R6 A unaffected", 3'd7, 8'hDE);
        swap_gen = 1; step();
        chk8("R6 main B back", 3'd0, 8'h12);

        // R7: DE/HL exchange
        xchg_dehl = 1; step();
        chk16("R7 DE", 2'd0, 2'd1, 16'h9ABC);
        chk16("R7 HL", 2'd0, 2'd2, 16'h5678);
        xchg_dehl = 1; step();
        chk16("R7 DE restored", 2'd0, 2'd1, 16'h5678);

        // R8/R9: refresh counter
        w8(3'd7, 8'h7E); step();
        ld_rfsh = 1; step();
        check("R9 load rfsh", {8'h00, rfsh_val}, 16'h007E);
        fetch_stb = 1; step();
        check("R8 step", {8'h00, rfsh_val}, 16'h007F);
        fetch_stb = 1; step();
        check("R8 wrap bit7 low", {8'h00, rfsh_val}, 16'h0000);
        w8(3'd7, 8'hFF); step();
        ld_rfsh = 1; step();
        fetch_stb = 1; step();
        check("R8 wrap bit7 kept", {8'h00, rfsh_val}, 16'h0080);
        w8(3'd7, 8'h33); step();
        ld_rfsh = 1; fetch_stb = 1; ld_ivec = 1; step();
        check("R9 load beats fetch", {8'h00, rfsh_val}, 16'h0033);
        check("R9 load ivec", {8'h00, ivec_val}, 16'h0033);

        // R10: write with swap in the same clock
        w8(3'd7, 8'h44); swap_af = 1; step();
        chk8("R10 alt A untouched", 3'd7, 8'h01);
        swap_af = 1; step();
        chk8("R10 write hit old bank", 3'd7, 8'h44);
        w16(2'd0, 2'd0, 16'hCAFE); swap_gen = 1; step();
        chk8("R10 alt B untouched", 3'd0, 8'hAA);
        swap_gen = 1; step();
        chk16("R10 BC in old bank", 2'd0, 2'd0, 16'hCAFE);

        // R11: overlapping writes
        w16(2'd0, 2'd1, 16'h1111); w8(3'd2, 8'h22); step();
        chk16("R11 8-bit over 16-bit", 2'd0, 2'd1, 16'h2211);
        xchg_dehl = 1; w8(3'd4, 8'h77); step();
        chk16("R11 exchange DE", 2'd0, 2'd1, 16'h9ABC);
        chk16("R11 write over exchange", 2'd0, 2'd2, 16'h7711);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule